// File: doc/BRIEF.md
# Radar Pulse Deframer with Baseband Conversion

This block sits behind a fiber receive port and turns its stream of 40-bit words into radar samples. While idle it hunts for a fixed preamble word that announces a new pulse. Once the preamble is seen, every following valid word carries one even and one odd 12-bit sample. Together these form an I/Q pair. Both samples are multiplied by (-1)^n, where n is the pair index within the pulse, and the result is offered to the write port of the main sample FIFO. After the last pair of a pulse the block goes back to hunting.

Each body word also carries one polarization bit and one auxiliary radar bit. These serial bits are packed into groups and written to a separate auxiliary FIFO. Counter chains track word position, pulse number and frame number for the receive side. A second chain does the same for words on the transmit side. Two test modes are provided: one treats every word as pulse data, and one replaces the large counter moduli with small ones.

Top module: `rdf_deframer`

## Requirements
- R1: While hunting, a valid word equal to the parameter `PREAMBLE` (all 40 bits) starts a pulse. Any other word is ignored and produces no sample write.
- R2: In a pulse body word, bits [11:0] are the even sample (I) and bits [23:12] are the odd sample (Q), both two's complement. The cycle after the word is accepted, `samp_wr` is 1 and `samp_data` = {Q, I}.
- R3: For pair index n (0 at the first body word), both samples are passed unchanged when n is even and negated when n is odd.
- R4: Negating -2048 gives +2047 (saturation), not -2048.
- R5: Bit 24 of a body word is the polarization bit and bit 25 is the auxiliary bit. After each group of `AUX_W` body words (pair indices k·AUX_W to k·AUX_W+AUX_W-1), `aux_wr` pulses for one cycle with `aux_data` = {polarization bits, auxiliary bits}. The first bit of the group is in the MSB of each half.
- R6: After the last pair of a pulse, hunting restarts. Words that follow are ignored until a preamble arrives.
- R7: `rx_word_idx` gives the pair index of the next body word. It wraps to 0 after `PAIRS` pairs (2032). At that point `rx_pulse_cnt` increments; it wraps after `PULSES` pulses (512), and then `rx_frame_cnt` increments.
- R8: With `bypass_sync` = 1, every valid word is treated as body data, with no preamble needed.
- R9: A write attempt while the matching FIFO's full input is 1 is dropped, and the sticky `overflow` output goes to 1. `overflow` stays 1 until reset, and the counters still advance.
- R10: With `short_count` = 1, the moduli become `SHORT_PAIRS` (32) pairs per pulse and `SHORT_PULSES` (4) pulses per frame.
- R11: Each `tx_valid` advances the transmit counters (`tx_word_idx`, `tx_pulse_cnt`, `tx_frame_cnt`) with the same moduli as the receive side.
- R12: After reset, all counters, `samp_wr`, `aux_wr` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_sync | input | 1 | Test mode: skip preamble hunt |
| short_count | input | 1 | Test mode: small counter moduli |
| in_valid | input | 1 | Receive word valid |
| in_word | input | 40 | Receive word |
| samp_full | input | 1 | Main sample FIFO full |
| aux_full | input | 1 | Auxiliary FIFO full |
| tx_valid | input | 1 | One transmit word passed |
| samp_wr | output | 1 | Main FIFO write strobe |
| samp_data | output | 24 | {Q, I} after sign alternation |
| aux_wr | output | 1 | Auxiliary FIFO write strobe |
| aux_data | output | 32 | {polarization bits, auxiliary bits} |
| overflow | output | 1 | Sticky FIFO overflow flag |
| in_pulse | output | 1 | A pulse body is in progress |
| rx_word_idx | output | 11 | Receive pair index |
| rx_pulse_cnt | output | 9 | Receive pulse within frame |
| rx_frame_cnt | output | 8 | Receive frame count |
| tx_word_idx | output | 11 | Transmit word index |
| tx_pulse_cnt | output | 9 | Transmit pulse within frame |
| tx_frame_cnt | output | 8 | Transmit frame count |

## Verification
The bench targets these corner cases:
- Saturating negation of -2048 at an odd pair. A design that wraps would emit -2048 where +2047 is due.
- Sign parity across pulses. A design whose sign toggle does not restart at each preamble would invert whole pulses.
- Hunting after the final pair. A design that stays locked would turn a trailing stray word into a sample write.
- Overflow. A design that stalls on a full FIFO would fall out of step with the pulse boundary, and one that clears the flag would lose the event.
- Counter boundaries. A full 2032-pair pulse and a short-mode frame rollover expose off-by-one moduli.
- Bit order of the auxiliary words.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int SAMP_W = 12;
  localparam int WORD_W = 40;

  typedef struct packed {
    logic signed [SAMP_W-1:0] q;
    logic signed [SAMP_W-1:0] i;
  } iq_t;

  // Negation that maps the most negative code to the most positive one.
  function automatic logic signed [SAMP_W-1:0] neg_sat(input logic signed [SAMP_W-1:0] v);
    logic signed [SAMP_W-1:0] lo;
    lo = {1'b1, {(SAMP_W-1){1'b0}}};
    if (v == lo) return {1'b0, {(SAMP_W-1){1'b1}}};
    return -v;
  endfunction

  function automatic logic signed [SAMP_W-1:0] alt_sign(input logic signed [SAMP_W-1:0] v,
                                                       input logic odd);
    return odd ? neg_sat(v) : v;
  endfunction
endpackage

// File: rtl/rdf_baseband.sv
module rdf_baseband
  import rdf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              odd_pair,
  output iq_t               iq
);
  logic signed [SAMP_W-1:0] even_s, odd_s;
  assign even_s = word[SAMP_W-1:0];
  assign odd_s  = word[2*SAMP_W-1:SAMP_W];

  always_comb begin
    iq.i = alt_sign(even_s, odd_pair);
    iq.q = alt_sign(odd_s, odd_pair);
  end
endmodule

// File: rtl/rdf_counters.sv
module rdf_counters #(
  parameter int PAIRS        = 2032,
  parameter int PULSES       = 512,
  parameter int SHORT_PAIRS  = 32,
  parameter int SHORT_PULSES = 4,
  parameter int FRAME_W      = 8,
  localparam int IDX_W = $clog2(PAIRS),
  localparam int PUL_W = $clog2(PULSES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               short_count,
  input  logic               step,
  output logic [IDX_W-1:0]   idx,
  output logic [PUL_W-1:0]   pulse,
  output logic [FRAME_W-1:0] frame,
  output logic [IDX_W-1:0]   last_idx,
  output logic               pulse_end,
  output logic               frame_end
);
  logic [PUL_W-1:0] last_pulse;

  assign last_idx   = short_count ? IDX_W'(SHORT_PAIRS - 1) : IDX_W'(PAIRS - 1);
  assign last_pulse = short_count ? PUL_W'(SHORT_PULSES - 1) : PUL_W'(PULSES - 1);
  assign pulse_end  = step && (idx == last_idx);
  assign frame_end  = pulse_end && (pulse == last_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      pulse <= '0;
      frame <= '0;
    end else if (step) begin
      if (pulse_end) begin
        idx <= '0;
        if (frame_end) begin
          pulse <= '0;
          frame <= frame + 1'b1;
        end else begin
          pulse <= pulse + 1'b1;
        end
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdf_aux_pack.sv
module rdf_aux_pack #(
  parameter int AUX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               pol_bit,
  input  logic               aux_bit,
  output logic [2*AUX_W-1:0] packed_word
);
  logic [AUX_W-2:0] pol_sr, aux_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_sr <= '0;
      aux_sr <= '0;
    end else if (step) begin
      pol_sr <= {pol_sr[AUX_W-3:0], pol_bit};
      aux_sr <= {aux_sr[AUX_W-3:0], aux_bit};
    end
  end

  // Earliest bit ends in the MSB once the final bit is appended.
  assign packed_word = {pol_sr, pol_bit, aux_sr, aux_bit};
endmodule

// File: rtl/rdf_deframer.sv
module rdf_deframer
  import rdf_pkg::*;
#(
  parameter logic [39:0] PREAMBLE = 40'hC3_5A96_A55A,
  parameter int PAIRS        = 2032,
  parameter int PULSES       = 512,
  parameter int SHORT_PAIRS  = 32,
  parameter int SHORT_PULSES = 4,
  parameter int FRAME_W      = 8,
  parameter int AUX_W        = 16,
  localparam int IDX_W   = $clog2(PAIRS),
  localparam int PUL_W   = $clog2(PULSES),
  localparam int AUX_LOG = $clog2(AUX_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bypass_sync,
  input  logic                short_count,
  input  logic                in_valid,
  input  logic [39:0]         in_word,
  input  logic                samp_full,
  input  logic                aux_full,
  input  logic                tx_valid,
  output logic                samp_wr,
  output logic [23:0]         samp_data,
  output logic                aux_wr,
  output logic [2*AUX_W-1:0]  aux_data,
  output logic                overflow,
  output logic                in_pulse,
  output logic [IDX_W-1:0]    rx_word_idx,
  output logic [PUL_W-1:0]    rx_pulse_cnt,
  output logic [FRAME_W-1:0]  rx_frame_cnt,
  output logic [IDX_W-1:0]    tx_word_idx,
  output logic [PUL_W-1:0]    tx_pulse_cnt,
  output logic [FRAME_W-1:0]  tx_frame_cnt
);
  // Named internal events for the checker.
  logic              pre_hit;
  logic              body_acc;
  logic              aux_req;
  logic              rx_pulse_end;
  logic              rx_frame_end;
  logic [IDX_W-1:0]  rx_last_idx;
  logic [IDX_W-1:0]  tx_last_idx;
  logic              tx_pulse_end, tx_frame_end;
  iq_t               bb_iq;
  logic [2*AUX_W-1:0] aux_packed;

  assign pre_hit  = in_valid && !in_pulse && !bypass_sync && (in_word == PREAMBLE);
  assign body_acc = in_valid && (in_pulse || bypass_sync);
  assign aux_req  = body_acc && (&rx_word_idx[AUX_LOG-1:0]);

  rdf_counters #(
    .PAIRS(PAIRS), .PULSES(PULSES), .SHORT_PAIRS(SHORT_PAIRS),
    .SHORT_PULSES(SHORT_PULSES), .FRAME_W(FRAME_W)
  ) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .short_count(short_count), .step(body_acc),
    .idx(rx_word_idx), .pulse(rx_pulse_cnt), .frame(rx_frame_cnt),
    .last_idx(rx_last_idx), .pulse_end(rx_pulse_end), .frame_end(rx_frame_end)
  );

  rdf_counters #(
    .PAIRS(PAIRS), .PULSES(PULSES), .SHORT_PAIRS(SHORT_PAIRS),
    .SHORT_PULSES(SHORT_PULSES), .FRAME_W(FRAME_W)
  ) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .short_count(short_count), .step(tx_valid),
    .idx(tx_word_idx), .pulse(tx_pulse_cnt), .frame(tx_frame_cnt),
    .last_idx(tx_last_idx), .pulse_end(tx_pulse_end), .frame_end(tx_frame_end)
  );

  rdf_baseband u_bb (
    .word(in_word), .odd_pair(rx_word_idx[0]), .iq(bb_iq)
  );

  rdf_aux_pack #(.AUX_W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .step(body_acc),
    .pol_bit(in_word[2*SAMP_W]), .aux_bit(in_word[2*SAMP_W+1]),
    .packed_word(aux_packed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse  <= 1'b0;
      samp_wr   <= 1'b0;
      samp_data <= '0;
      aux_wr    <= 1'b0;
      aux_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (pre_hit)
        in_pulse <= 1'b1;
      else if (rx_pulse_end)
        in_pulse <= 1'b0;

      samp_wr <= body_acc && !samp_full;
      if (body_acc)
        samp_data <= bb_iq;

      aux_wr <= aux_req && !aux_full;
      if (aux_req)
        aux_data <= aux_packed;

      if ((body_acc && samp_full) || (aux_req && aux_full))
        overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
  parameter int IDX_W   = 11,
  parameter int AUX_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pre_hit,
  input logic             body_acc,
  input logic             aux_req,
  input logic             in_valid,
  input logic             in_pulse,
  input logic             bypass_sync,
  input logic [39:0]      in_word,
  input logic             samp_full,
  input logic             samp_wr,
  input logic [23:0]      samp_data,
  input logic             aux_wr,
  input logic             overflow,
  input logic [IDX_W-1:0] rx_word_idx,
  input logic [IDX_W-1:0] rx_last_idx
);
  // R1: a hunting cycle without a preamble hit writes nothing
  p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pulse && !bypass_sync && !pre_hit) |=> !samp_wr);

  // R4: -2048 at an odd pair leaves as +2047
  p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (body_acc && rx_word_idx[0] && in_word[11:0] == 12'h800) |=> samp_data[11:0] == 12'h7FF);

  // R3: even pairs pass the I sample through untouched
  p_even_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (body_acc && !rx_word_idx[0] && !samp_full) |=> samp_wr && samp_data[11:0] == $past(in_word[11:0]));

  // R9: write under full is dropped and flagged
  p_no_overflow_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (body_acc && samp_full) |=> !samp_wr && overflow);

  // R9: the flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7: the pair index never passes the active modulus
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_idx <= rx_last_idx);

  // R5: an auxiliary write follows only a group-closing body word
  p_aux_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |-> $past(aux_req));

  // R6: a pulse ends after its last pair
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (body_acc && in_pulse && rx_word_idx == rx_last_idx) |=> !in_pulse);
endmodule

bind rdf_deframer rdf_checker #(.IDX_W(IDX_W), .AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_hit(pre_hit), .body_acc(body_acc),
  .aux_req(aux_req), .in_valid(in_valid), .in_pulse(in_pulse),
  .bypass_sync(bypass_sync), .in_word(in_word), .samp_full(samp_full),
  .samp_wr(samp_wr), .samp_data(samp_data), .aux_wr(aux_wr),
  .overflow(overflow), .rx_word_idx(rx_word_idx), .rx_last_idx(rx_last_idx)
);

// File: tb/sim_rdf_deframer.sv
module sim_rdf_deframer;
  localparam logic [39:0] PRE = 40'hC3_5A96_A55A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_sync = 0, short_count = 1, in_valid = 0, samp_full = 0, aux_full = 0, tx_valid = 0;
  logic [39:0] in_word = '0;
  logic samp_wr, aux_wr, overflow, in_pulse;
  logic [23:0] samp_data;
  logic [31:0] aux_data;
  logic [10:0] rx_word_idx, tx_word_idx;
  logic [8:0]  rx_pulse_cnt, tx_pulse_cnt;
  logic [7:0]  rx_frame_cnt, tx_frame_cnt;

  int vectors = 0, errors = 0;
  int exp_pulse = 0, exp_frame = 0;

  always #2.5 clk = ~clk;

  rdf_deframer u0 (
    .clk(clk), .rst_n(rst_n), .bypass_sync(bypass_sync), .short_count(short_count),
    .in_valid(in_valid), .in_word(in_word), .samp_full(samp_full), .aux_full(aux_full),
    .tx_valid(tx_valid), .samp_wr(samp_wr), .samp_data(samp_data), .aux_wr(aux_wr),
    .aux_data(aux_data), .overflow(overflow), .in_pulse(in_pulse),
    .rx_word_idx(rx_word_idx), .rx_pulse_cnt(rx_pulse_cnt), .rx_frame_cnt(rx_frame_cnt),
    .tx_word_idx(tx_word_idx), .tx_pulse_cnt(tx_pulse_cnt), .tx_frame_cnt(tx_frame_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_samp(input int v, input int n);
    if (n % 2 == 0) return v;
    if (v == -2048) return 2047;
    return -v;
  endfunction

  function automatic logic [39:0] mk(input int e, input int o, input bit p, input bit a);
    logic [11:0] e12, o12;
    e12 = e[11:0];
    o12 = o[11:0];
    return {14'h0, a, p, o12, e12};
  endfunction

  // Apply one word; on return, outputs reflect it (called at a negedge).
  task automatic send(input logic [39:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_done();
    exp_pulse++;
    if (exp_pulse == (short_count ? 4 : 512)) begin
      exp_pulse = 0;
      exp_frame++;
    end
  endtask

  task automatic t_reset();
    chk(!samp_wr && !aux_wr && !overflow, "R12 strobes", {samp_wr, aux_wr, overflow}, 0);
    chk(rx_word_idx == 0 && rx_pulse_cnt == 0 && rx_frame_cnt == 0, "R12 rx counters",
        rx_word_idx, 0);
    chk(tx_word_idx == 0 && tx_pulse_cnt == 0 && tx_frame_cnt == 0, "R12 tx counters",
        tx_word_idx, 0);
  endtask

  task automatic t_hunt();
    for (int k = 0; k < 5; k++) begin
      send(PRE ^ (40'h1 << (k * 9)));
      chk(!samp_wr && rx_word_idx == 0, "R1 near-miss ignored", samp_wr, 0);
    end
    send(PRE);
    chk(!samp_wr && in_pulse, "R1 preamble locks", in_pulse, 1);
  endtask

  // Full short pulse: sign alternation, saturation, aux packing.
  task automatic t_body();
    logic [15:0] pol_exp, aux_exp;
    for (int n = 0; n < 32; n++) begin
      int e, o;
      bit p, a;
      e = (n == 3) ? -2048 : (n == 6 ? -2048 : n * 37 - 600);
      o = (n == 5) ? -2048 : 1000 - n * 53;
      p = ((n * 7) % 3) == 0;
      a = ((n * 5) % 4) < 2;
      pol_exp = {pol_exp[14:0], p};
      aux_exp = {aux_exp[14:0], a};
      send(mk(e, o, p, a));
      chk(samp_wr, "R2 write strobe", samp_wr, 1);
      chk($signed(samp_data[11:0]) == expect_samp(e, n), (n == 3) ? "R4 saturate I" : "R3 I sign",
          samp_data[11:0], expect_samp(e, n));
      chk($signed(samp_data[23:12]) == expect_samp(o, n), (n == 5) ? "R4 saturate Q" : "R3 Q sign",
          samp_data[23:12], expect_samp(o, n));
      if (n % 16 == 15)
        chk(aux_wr && aux_data == {pol_exp, aux_exp}, "R5 aux word", aux_data, {pol_exp, aux_exp});
      else
        chk(!aux_wr, "R5 no aux mid-group", aux_wr, 0);
    end
    pulse_done();
    chk(rx_word_idx == 0 && rx_pulse_cnt == exp_pulse, "R10 short pulse wrap", rx_pulse_cnt, exp_pulse);
  endtask

  task automatic t_restart();
    send(mk(100, 200, 0, 0));
    chk(!samp_wr && !in_pulse, "R6 trailing word ignored", samp_wr, 0);
    send(PRE);
    send(mk(-5, 9, 0, 0));
    chk(samp_wr && samp_data == {12'd9, 12'hFFB}, "R6 new pulse sign restarts", samp_data,
        {12'd9, 12'hFFB});
    for (int n = 1; n < 32; n++) send(mk(n, n, 0, 0));
    pulse_done();
  endtask

  task automatic t_frame();
    while (exp_pulse != 0) begin
      send(PRE);
      for (int n = 0; n < 32; n++) send(mk(n, -n, 1, 0));
      pulse_done();
    end
    chk(rx_pulse_cnt == 0 && rx_frame_cnt == exp_frame, "R10 frame rollover", rx_frame_cnt, exp_frame);
  endtask

  task automatic t_long();
    short_count = 1'b0;
    send(PRE);
    for (int n = 0; n < 2031; n++) send(mk(n % 2000, 0, 0, 0));
    chk(rx_word_idx == 2031 && in_pulse, "R7 index reaches 2031", rx_word_idx, 2031);
    send(mk(7, 7, 0, 0));
    chk(samp_data == {-12'sd7, -12'sd7}, "R3 last odd pair negated", samp_data, {-12'sd7, -12'sd7});
    pulse_done();
    chk(rx_word_idx == 0 && rx_pulse_cnt == exp_pulse && !in_pulse, "R7 long pulse wrap",
        rx_pulse_cnt, exp_pulse);
    short_count = 1'b1;
  endtask

  task automatic t_bypass();
    bypass_sync = 1'b1;
    for (int n = 0; n < 32; n++) begin
      send(mk(n + 1, 0, 0, 0));
      chk(samp_wr && $signed(samp_data[11:0]) == expect_samp(n + 1, n), "R8 bypass data",
          samp_data[11:0], expect_samp(n + 1, n));
    end
    pulse_done();
    chk(rx_pulse_cnt == exp_pulse, "R8 bypass counts pulses", rx_pulse_cnt, exp_pulse);
    bypass_sync = 1'b0;
    send(mk(3, 3, 0, 0));
    chk(!samp_wr, "R8 hunt resumes", samp_wr, 0);
  endtask

  task automatic t_overflow();
    chk(!overflow, "R9 clean before", overflow, 0);
    send(PRE);
    samp_full = 1'b1;
    send(mk(1, 1, 0, 0));
    samp_full = 1'b0;
    chk(!samp_wr && overflow && rx_word_idx == 1, "R9 drop and flag", {samp_wr, overflow}, 1);
    send(mk(2, 2, 0, 0));
    chk(samp_wr && overflow && samp_data[11:0] == 12'hFFE, "R9 sticky, next pair odd",
        samp_data[11:0], 12'hFFE);
    for (int n = 2; n < 32; n++) send(mk(0, 0, 0, 0));
    pulse_done();
  endtask

  task automatic t_tx();
    for (int n = 0; n < 33; n++) begin
      tx_valid = 1'b1;
      @(negedge clk);
    end
    tx_valid = 1'b0;
    chk(tx_word_idx == 1 && tx_pulse_cnt == 1 && tx_frame_cnt == 0, "R11 tx counters",
        {tx_pulse_cnt, tx_word_idx}, {9'd1, 11'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hunt();
    t_body();
    t_restart();
    t_frame();
    t_long();
    t_bypass();
    t_tx();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule